// File: doc/BRIEF.md
# Feedback-Regulated LED PWM Duty Controller

This block sets the brightness of an LED string in a switching supply. It holds a 4-bit duty code and turns it into a pulse-width-modulated switch drive with a 16-cycle period. Two digital feedback flags steer the code:

- `fb_lit` says that current is flowing in the LED.
- `below_rated` says that the output voltage is still under its target.

While the LED is dark, the code waits at a fixed start value. Once the LED conducts, the code climbs while the output is low and falls once the target is reached. This makes the output voltage hunt in a narrow band around its rated value.

Two mode pins enable regulation. With both pins low the block is idle: the drive stays low and the code stays at the start value. The two feedback flags come from analog comparators and may change at any time, so each passes through a two-flop synchronizer before it is used. The code moves only on the last cycle of a PWM period, so every period is drawn from one code.

Top module: `lum_regulator`

## Requirements
- R1: While `rst_n` is low at a clock edge, the duty code becomes 4, the PWM phase returns to 0 and `pwm_drive` goes low. After reset is released, the first PWM period starts at phase 0.
- R2: When regulation is enabled but the synchronized `fb_lit` is 0, the duty code is forced to 4 at every clock edge, whatever the period position.
- R3: When enabled, lit and with synchronized `below_rated` = 1, the code rises by exactly one at each period boundary. It stops at 10, which is a 62.5% duty.
- R4: When enabled, lit and with synchronized `below_rated` = 0, the code falls by exactly one at each period boundary. It stops at 3, which is an 18.75% duty.
- R5: The count direction follows the comparator at every boundary. A comparator that toggles makes the code reverse, so it hunts around the level where the comparator flips.
- R6: With `mode_a` = `mode_b` = 0, `pwm_drive` is low one cycle later and the code is forced to 4. Any other combination of the two pins enables regulation.
- R7: The PWM period is 16 clocks. The drive for phase p (0..15) appears one cycle after phase p and is high when p < code, so each period holds exactly `code` high cycles.
- R8: The code changes only at the edge where the phase wraps from 15 to 0, except when it is forced by R2 or R6.
- R9: A change on `fb_lit` or `below_rated` is first used by the logic at the third rising edge after it is applied, because it passes through two register stages.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_a | input | 1 | Mode pin A; regulation runs unless both mode pins are 0 |
| mode_b | input | 1 | Mode pin B |
| fb_lit | input | 1 | Asynchronous flag: LED feedback voltage present |
| below_rated | input | 1 | Asynchronous flag: output below rated voltage |
| pwm_drive | output | 1 | Registered switch drive |
| duty_code | output | 4 | Current duty code (duty = code/16) |

## Verification
The assertions assume that the mode pins are quasi-static and synchronous to `clk`, since they are used without synchronization. They also assume that the start code lies between the clamp limits. The bench changes the mode pins and both feedback flags only on falling clock edges, so the synchronizers always capture a settled level. It compares the outputs on every cycle with a behavioural model that includes the same two-stage delay.

The stimulus covers several cases:
- long steady runs that reach both clamps;
- comparator toggles at several rates to show the hunting;
- a closed loop in which the model's own code drives the comparator;
- loss of the lit flag in mid-period;
- every mode-pin combination;
- a reset in the middle of a run.

// File: rtl/lumreg_pkg.sv
// Shared types for the LED duty regulator.
// Assumes nothing beyond a common clock domain for all users.
package lumreg_pkg;

    // Step direction chosen for the duty code at a period boundary
    typedef enum logic [1:0] {
        STEP_HOLD   = 2'd0,
        STEP_UP     = 2'd1,
        STEP_DOWN   = 2'd2,
        STEP_PRESET = 2'd3
    } step_e;

endpackage

// File: rtl/fb_sync.sv
// Multi-stage synchronizer for asynchronous feedback flags.
// Assumes each input is a level that holds for several clock cycles.
module fb_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                // Capture the raw asynchronous level
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level down the chain
                always_ff @(posedge clk) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/pwm_slicer.sv
// Free-running phase counter and duty comparator.
// Produces a registered drive that is high for `code` cycles in each period.
// Assumes `code` changes only on the cycle that tick is high, or when forced.
module pwm_slicer #(
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick,
    output logic              pwm
);

    localparam logic [CODE_W-1:0] PHASE_LAST = {CODE_W{1'b1}};

    logic [CODE_W-1:0] phase_q;

    // Advance the phase and wrap naturally at the end of the period
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= '0;
        else        phase_q <= phase_q + 1'b1;
    end

    assign tick = (phase_q == PHASE_LAST);

    // Register the comparison so the drive is glitch-free and low in reset
    always_ff @(posedge clk) begin
        if (!rst_n) pwm <= 1'b0;
        else        pwm <= run && (phase_q < code);
    end

    // R6
    // idle_low_chk
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm);

    // R7
    // Nothing is driven on the last phase, whatever the code
    last_phase_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !pwm);

endmodule

// File: rtl/duty_regulator.sv
// Saturating up/down duty-code counter steered by comparator feedback.
// Presets to START while the LED is dark or regulation is off.
// Otherwise it steps once per period.
// Assumes LO <= START <= HI and that lit/below are already synchronized.
module duty_regulator
    import lumreg_pkg::*;
#(
    parameter int CODE_W = 4,
    parameter int START  = 4,
    parameter int HI     = 10,
    parameter int LO     = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              lit,
    input  logic              below,
    input  logic              tick,
    output logic [CODE_W-1:0] code
);

    localparam logic [CODE_W-1:0] CODE_START = CODE_W'(START);
    localparam logic [CODE_W-1:0] CODE_HI    = CODE_W'(HI);
    localparam logic [CODE_W-1:0] CODE_LO    = CODE_W'(LO);

    step_e             step;
    logic [CODE_W-1:0] code_d;

    // Choose the step for this cycle from the mode and the feedback
    always_comb begin
        if (!run || !lit)     step = STEP_PRESET;
        else if (!tick)       step = STEP_HOLD;
        else if (below)       step = STEP_UP;
        else                  step = STEP_DOWN;
    end

    // Apply the step with clamping at both ends
    always_comb begin
        unique case (step)
            STEP_PRESET: code_d = CODE_START;
            STEP_UP:     code_d = (code >= CODE_HI) ? CODE_HI : code + 1'b1;
            STEP_DOWN:   code_d = (code <= CODE_LO) ? CODE_LO : code - 1'b1;
            default:     code_d = code;
        endcase
    end

    // Hold the duty code
    always_ff @(posedge clk) begin
        if (!rst_n) code <= CODE_START;
        else        code <= code_d;
    end

    // R3
    // code_range_chk
    code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (code <= CODE_HI) && (code >= CODE_LO));

    // R2
    // preset_chk
    preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run || !lit) |=> (code == CODE_START));

    // R8
    // mid_period_hold_chk
    mid_period_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lit && !tick) |=> $stable(code));

    // R4
    // single_step_chk
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && lit && tick) |=>
            ((code == $past(code)) || (code == $past(code) + 1'b1) ||
             (code == $past(code) - 1'b1)));

endmodule

// File: rtl/lum_regulator.sv
// Top of the LED brightness regulator.
// Synchronizes the two feedback flags, runs the duty counter and slices
// the code into a 16-slot PWM drive.
// Assumes mode_a/mode_b are synchronous, quasi-static pins.
module lum_regulator #(
    parameter int CODE_W      = 4,
    parameter int START_CODE  = 4,
    parameter int CODE_MAX    = 10,
    parameter int CODE_MIN    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_a,
    input  logic              mode_b,
    input  logic              fb_lit,
    input  logic              below_rated,
    output logic              pwm_drive,
    output logic [CODE_W-1:0] duty_code
);

    localparam int FLAG_N = 2;

    logic [FLAG_N-1:0] flags_s;
    logic              run;
    logic              tick;

    assign run = mode_a | mode_b;

    fb_sync #(
        .WIDTH  (FLAG_N),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({below_rated, fb_lit}),
        .sync_out (flags_s)
    );

    duty_regulator #(
        .CODE_W (CODE_W),
        .START  (START_CODE),
        .HI     (CODE_MAX),
        .LO     (CODE_MIN)
    ) i_duty (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .lit   (flags_s[0]),
        .below (flags_s[1]),
        .tick  (tick),
        .code  (duty_code)
    );

    pwm_slicer #(
        .CODE_W (CODE_W)
    ) i_pwm (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (run),
        .code  (duty_code),
        .tick  (tick),
        .pwm   (pwm_drive)
    );

endmodule

// File: tb/test_lum_regulator.sv
`timescale 1ns/1ps
module test_lum_regulator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_a = 1'b0, mode_b = 1'b0;
    logic       fb_lit = 1'b0, below_rated = 1'b0;
    logic       pwm_drive;
    logic [3:0] duty_code;

    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;
    bit    finished = 1'b0;
    string tag = "R1";

    // Behavioural reference state
    int m_phase = 0, m_duty = 4;
    bit m_pwm = 0;
    bit lit_q[$], blw_q[$];

    always #2 clk = ~clk;

    lum_regulator i_lum_regulator (
        .clk(clk), .rst_n(rst_n), .mode_a(mode_a), .mode_b(mode_b),
        .fb_lit(fb_lit), .below_rated(below_rated),
        .pwm_drive(pwm_drive), .duty_code(duty_code)
    );

    // Reference model, advanced at each rising edge
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            lit_q = '{0, 0}; blw_q = '{0, 0};
            m_phase = 0; m_duty = 4; m_pwm = 0;
        end else begin
            bit run, lit, blw;
            int nd;
            run = mode_a || mode_b;
            lit = lit_q[0]; blw = blw_q[0];
            m_pwm = run && (m_phase < m_duty);
            nd = m_duty;
            if (!run || !lit) nd = 4;
            else if (m_phase == 15) nd = blw ? ((m_duty < 10) ? m_duty + 1 : 10)
                                             : ((m_duty > 3) ? m_duty - 1 : 3);
            m_duty = nd;
            void'(lit_q.pop_front()); lit_q.push_back(fb_lit);
            void'(blw_q.pop_front()); blw_q.push_back(below_rated);
            m_phase = (m_phase + 1) % 16;
        end
    end

    task automatic check_now();
        vectors++;
        if (duty_code !== 4'(m_duty)) begin
            miscompares++;
            $display("FAIL %s duty_code got %0d expected %0d at cycle %0d",
                     tag, duty_code, m_duty, cycles);
        end
        if (pwm_drive !== m_pwm) begin
            miscompares++;
            $display("FAIL %s pwm_drive got %0b expected %0b at cycle %0d",
                     tag, pwm_drive, m_pwm, cycles);
        end
    endtask

    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_now();
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1: reset state
        tag = "R1";
        step(3);
        if (duty_code !== 4'd4 || pwm_drive !== 1'b0) begin
            miscompares++;
            $display("FAIL R1 reset got code %0d pwm %0b expected 4 0", duty_code, pwm_drive);
        end
        vectors++;
        rst_n = 1'b1;
        // R6: idle with the feedback asserted
        tag = "R6"; fb_lit = 1; below_rated = 1;
        step(40);
        // R2: enabled but dark
        tag = "R2"; mode_a = 1; fb_lit = 0;
        step(40);
        // R3 and R9: climb to the upper clamp
        tag = "R3"; fb_lit = 1; below_rated = 1;
        step(200);
        // R4: descend to the lower clamp
        tag = "R4"; mode_a = 0; mode_b = 1; below_rated = 0;
        step(200);
        // R5: toggle the comparator every period and every few periods
        tag = "R5"; mode_a = 1;
        for (int k = 0; k < 12; k++) begin below_rated = ~below_rated; step(16); end
        for (int k = 0; k < 8; k++) begin below_rated = ~below_rated; step(45); end
        // R5: closed loop driven by the model's own code
        for (int k = 0; k < 300; k++) begin below_rated = (m_duty < 7); step(1); end
        // R9: short pulses on the flags and a lit drop in mid-period
        tag = "R9";
        for (int k = 0; k < 10; k++) begin
            fb_lit = 0; step(k % 3 + 1);
            fb_lit = 1; below_rated = k[0]; step(k + 5);
        end
        // R7 and R8: steady codes at several levels
        tag = "R7";
        below_rated = 1; step(100);
        below_rated = 0; step(24);
        tag = "R8"; step(60);
        // R6: each mode combination
        tag = "R6";
        mode_a = 0; mode_b = 0; step(20);
        mode_a = 1; mode_b = 0; below_rated = 1; step(50);
        mode_a = 0; mode_b = 1; step(30);
        mode_a = 0; mode_b = 0; step(5);
        // R1: reset in the middle of a run
        tag = "R1"; mode_a = 1; step(70);
        rst_n = 0; step(3);
        rst_n = 1; step(60);
        finish_run();
    end

endmodule